// File: doc/BRIEF.md
# Self-Timed Data Memory Access Controller

This block fronts a byte-wide data memory of 2048 locations that is reached through a register-gated bus. A small control register carries a memory-select bit and a write-permit bit. While memory-select is clear, every bus strobe, address and data byte is passed to an external-memory port instead, and read data is taken from that port. While it is set, strobes reach the internal storage, and a write is taken only if write-permit is also set.

An accepted write stores its byte at once and then starts a self-timed programming window of `WR_CYCLES` clock cycles. During that window a read-only ready bit in the control register reads 0. A read of the location being programmed returns the stored byte with its most significant bit inverted. Reads of other locations are unaffected. A write that arrives during the window is dropped and sets a sticky overrun bit, which software clears by writing 1 to it. The default window is 250000 cycles, which is 2.5 ms at 100 MHz. A bench can set a short value.

Top module: `nvdata_ctl`

## Requirements
- R1: After reset the control register reads 4'b0100: memory-select (bit 0) = 0, write-permit (bit 1) = 0, ready (bit 2) = 1, overrun (bit 3) = 0. No external strobe is active.
- R2: With memory-select = 0, bus_rd and bus_wr appear on ext_rd and ext_wr in the same cycle, with ext_addr = bus_addr and ext_wdata = bus_wdata. A read returns ext_rdata on bus_rdata one cycle after the strobe. Internal storage and ready are unchanged.
- R3: With memory-select = 1, ext_rd and ext_wr stay 0. A read strobe in one cycle puts the stored byte on bus_rdata after the next rising edge.
- R4: With memory-select = 1 and write-permit = 0, a write strobe is ignored. Storage keeps its value and ready stays 1.
- R5: An accepted write drives ready to 0 from the edge that takes it for exactly WR_CYCLES cycles. Ready then returns to 1.
- R6: A read, while ready = 0, of the address being programmed returns the new byte with bit 7 inverted. Other addresses read their true contents. After ready returns to 1, the true byte is read.
- R7: The write data is captured at the accepting edge. Later values on bus_wdata have no effect on the stored byte.
- R8: A write strobe with both control bits set while ready = 0 is ignored and sets overrun (bit 3). Overrun stays set until a control write with bit 3 = 1, and it does not alter the programming window in progress.
- R9: A control write loads bits 0 and 1 from ctl_wdata. Bit 2 (ready) is read-only, so writing it has no effect. Bits 3..0 of ctl_rdata are overrun, ready, write-permit and memory-select.
- R10: Addresses 0x000 through 0x7FF are distinct locations. A write to 0x7FF does not disturb 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data (bit 3 clears overrun, bit 1 write-permit, bit 0 memory-select) |
| ctl_rdata | output | 4 | Control register view {overrun, ready, write-permit, memory-select} |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| ext_addr | output | 11 | Address to external memory |
| ext_wdata | output | 8 | Write data to external memory |
| ext_rdata | input | 8 | Read data from external memory |
| ext_rd | output | 1 | Read strobe to external memory |
| ext_wr | output | 1 | Write strobe to external memory |

## Verification
The assertions assume that a control write and a bus strobe never fall in the same cycle. They also assume that strobes are single-cycle pulses, so each cycle with a strobe high counts as one access. The bench keeps to this by driving every access from a task that raises one strobe for one cycle and lowers it before the next task begins. Random writes first poll ready, so overrun appears only in the directed case built to cause it. Reads in the random phase target only locations the bench has already written, so every expected value is known.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  localparam int CTL_W   = 4;
  localparam int CTL_MEN = 0;
  localparam int CTL_WEN = 1;
  localparam int CTL_RDY = 2;
  localparam int CTL_OVR = 3;

  typedef struct packed {
    logic ovr;
    logic rdy;
    logic wen;
    logic men;
  } ctl_view_t;
endpackage

// File: rtl/nvc_rst_sync.sv
module nvc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/nvc_ctl_reg.sv
module nvc_ctl_reg
  import nvc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ovr_set,
  output logic             men,
  output logic             wen,
  output logic             ovr
);
  logic men_d, wen_d, ovr_d;
  logic men_q, wen_q, ovr_q;
  logic unused_rdy_bit;

  assign unused_rdy_bit = wdata[CTL_RDY];

  always_comb begin
    men_d = men_q;
    wen_d = wen_q;
    ovr_d = ovr_q;
    if (wr) begin
      men_d = wdata[CTL_MEN];
      wen_d = wdata[CTL_WEN];
      if (wdata[CTL_OVR]) ovr_d = 1'b0;
    end
    if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= 1'b0;
      wen_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      men_q <= men_d;
      wen_q <= wen_d;
      ovr_q <= ovr_d;
    end
  end

  assign men = men_q;
  assign wen = wen_q;
  assign ovr = ovr_q;
endmodule

// File: rtl/nvc_wr_timer.sv
module nvc_wr_timer #(
  parameter int CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  generate
    if (CYC == 1) begin : g_single
      logic b_d, b_q;
      always_comb b_d = start;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else        b_q <= b_d;
      end
      assign busy = b_q;
    end else begin : g_count
      localparam int CNT_W = $clog2(CYC + 1);
      logic [CNT_W-1:0] cnt_d, cnt_q;
      logic             cnt_en;
      always_comb begin
        cnt_en = start || (cnt_q != '0);
        if (start) cnt_d = CNT_W'(CYC);
        else       cnt_d = cnt_q - 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
      assign busy = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/nvc_store.sv
module nvc_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/nvdata_ctl.sv
module nvdata_ctl
  import nvc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_rd,
  output logic              ext_wr
);
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic              rst_n_s;
  logic              men, wen, ovr, busy;
  logic              wr_take, wr_overrun;
  logic              prog_hit;
  logic [DATA_W-1:0] arr_dout;
  logic [ADDR_W-1:0] paddr_d, paddr_q;
  logic [DATA_W-1:0] rdat_d, rdat_q;
  ctl_view_t         view;

  nvc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign wr_take    = bus_wr && men && wen && !busy;
  assign wr_overrun = bus_wr && men && wen &&  busy;

  nvc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n_s), .wr(ctl_wr), .wdata(ctl_wdata),
    .ovr_set(wr_overrun), .men(men), .wen(wen), .ovr(ovr)
  );

  nvc_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .start(wr_take), .busy(busy)
  );

  nvc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_take), .waddr(bus_addr), .wdata(bus_wdata),
    .raddr(bus_addr), .rdata(arr_dout)
  );

  always_comb paddr_d = bus_addr;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     paddr_q <= '0;
    else if (wr_take) paddr_q <= paddr_d;
  end

  assign prog_hit = busy && (bus_addr == paddr_q);

  always_comb begin
    if (men) rdat_d = prog_hit ? (arr_dout ^ MSB_MASK) : arr_dout;
    else     rdat_d = ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdat_q <= '0;
    else if (bus_rd) rdat_q <= rdat_d;
  end

  assign bus_rdata = rdat_q;
  assign ext_rd    = bus_rd && !men;
  assign ext_wr    = bus_wr && !men;
  assign ext_addr  = bus_addr;
  assign ext_wdata = bus_wdata;

  always_comb begin
    view.ovr = ovr;
    view.rdy = !busy;
    view.wen = wen;
    view.men = men;
  end
  assign ctl_rdata = view;
endmodule

// File: rtl/nvdata_ctl_chk.sv
module nvdata_ctl_chk #(
  parameter int WR_CYCLES = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [3:0] ctl_wdata,
  input logic [3:0] ctl_rdata,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       ext_rd,
  input logic       ext_wr
);
  logic [31:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_q <= '0;
    else if (ctl_rdata[2]) low_q <= '0;
    else                   low_q <= low_q + 1'b1;
  end

  AST_EXT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[0] && bus_rd) |-> ext_rd); // R2
  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] |-> (!ext_rd && !ext_wr)); // R3
  AST_NOPERMIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ctl_rdata[0] && !ctl_rdata[1] && ctl_rdata[2]) |=> ctl_rdata[2]); // R4
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ctl_rdata[0] && ctl_rdata[1] && ctl_rdata[2]) |=> !ctl_rdata[2]); // R5
  AST_WINDOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= WR_CYCLES); // R5
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[2]) |-> (low_q == WR_CYCLES)); // R5
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[3]) |-> $past(bus_wr && ctl_rdata[0] && ctl_rdata[1] && !ctl_rdata[2])); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[3] && !(ctl_wr && ctl_wdata[3])) |=> ctl_rdata[3]); // R8
endmodule

bind nvdata_ctl nvdata_ctl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .ext_rd(ext_rd), .ext_wr(ext_wr)
);

// File: tb/sim_nvdata_ctl.sv
`timescale 1ns/1ps
module sim_nvdata_ctl;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [3:0]  ctl_wdata;
  logic [3:0]  ctl_rdata;
  logic [10:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_rdata;
  logic [10:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic        ext_rd, ext_wr;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [2048];
  bit         known [2048];

  always #5 clk = ~clk;

  nvdata_ctl #(.WR_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ext_rd(ext_rd), .ext_wr(ext_wr)
  );

  function automatic logic [7:0] ext_val(input logic [10:0] a);
    return a[7:0] ^ {5'b0, a[10:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] busy_view(input logic [7:0] d);
    return d ^ 8'h80;
  endfunction

  assign ext_rdata = ext_val(ext_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [3:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 4'h0;
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = ~d;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] q);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; q = bus_rdata;
  endtask

  task automatic wait_ready();
    while (!ctl_rdata[2]) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic       seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctl_wr = 0; ctl_wdata = 0; bus_addr = 0; bus_wdata = 0;
    bus_rd = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 ctl reset", ctl_rdata, 4'b0100);
    check("R1 ext idle", {ext_rd, ext_wr}, 2'b00);

    ctl_write(4'b0011);
    check("R9 ctl layout", ctl_rdata, 4'b0111);

    // R5 exact window
    bus_write(11'h000, 8'hA5);
    model[0] = 8'hA5; known[0] = 1;
    seen = 1'b0;
    for (int k = 0; k < W - 1; k++) begin
      if (ctl_rdata[2]) seen = 1'b1;
      @(negedge clk);
    end
    check("R5 ready low whole window", {seen, ctl_rdata[2]}, 2'b00);
    @(negedge clk);
    check("R5 ready back after window", ctl_rdata[2], 1'b1);
    bus_read(11'h000, q);
    check("R3 read stored", q, 8'hA5);

    // R6 / R10 / R7
    bus_write(11'h7FF, 8'h3C);
    model[2047] = 8'h3C; known[2047] = 1;
    bus_read(11'h7FF, q);
    check("R6 busy read inverted", q, busy_view(8'h3C));
    bus_read(11'h000, q);
    check("R6 other addr true during busy", q, 8'hA5);
    wait_ready();
    bus_read(11'h7FF, q);
    check("R7 latched data after bus change", q, 8'h3C);
    bus_read(11'h000, q);
    check("R10 low addr kept", q, 8'hA5);

    // R8 overrun
    bus_write(11'h010, 8'h11);
    bus_write(11'h010, 8'h22);
    model[16] = 8'h11; known[16] = 1;
    check("R8 overrun set", ctl_rdata, 4'b1011);
    wait_ready();
    bus_read(11'h010, q);
    check("R8 dropped write", q, 8'h11);
    check("R8 overrun sticky", ctl_rdata[3], 1'b1);
    ctl_write(4'b1011);
    check("R8 R9 clear ovr ready ro", ctl_rdata, 4'b0111);

    // R4 no permit
    ctl_write(4'b0001);
    bus_write(11'h000, 8'h77);
    check("R4 ready stays", ctl_rdata[2], 1'b1);
    bus_read(11'h000, q);
    check("R4 storage kept", q, 8'hA5);

    // R2 external
    ctl_write(4'b0000);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 11'h000; bus_wdata = 8'h99;
    #1;
    check("R2 ext_wr", {ext_wr, ext_rd}, 2'b10);
    check("R2 ext addr data", {ext_addr, ext_wdata}, {11'h000, 8'h99});
    @(negedge clk); bus_wr = 1'b0;
    check("R2 ready untouched", ctl_rdata[2], 1'b1);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 11'h123;
    #1;
    check("R2 ext_rd", ext_rd, 1'b1);
    @(negedge clk); bus_rd = 1'b0;
    check("R2 ext read data", bus_rdata, ext_val(11'h123));
    ctl_write(4'b0001);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 11'h000;
    #1;
    check("R3 ext quiet", ext_rd, 1'b0);
    @(negedge clk); bus_rd = 1'b0;
    check("R2 storage unaffected", bus_rdata, 8'hA5);

    // random phase
    ctl_write(4'b0011);
    for (int i = 0; i < 250; i++) begin
      logic [10:0] a;
      logic [7:0]  d;
      a = 11'($urandom_range(0, 255)) | (($urandom % 4 == 0) ? 11'h700 : 11'h000);
      d = 8'($urandom);
      if (($urandom % 2 == 0) || !known[a]) begin
        wait_ready();
        bus_write(a, d);
        model[a] = d; known[a] = 1;
        check("R5 busy after take", ctl_rdata[2], 1'b0);
        bus_read(a, q);
        check("R6 random busy read", q, busy_view(d));
        wait_ready();
        bus_read(a, q);
        check("R6 random settled read", q, d);
      end else begin
        bus_read(a, q);
        check("R3 random read", q, model[a]);
      end
    end
    check("R8 no random overrun", ctl_rdata[3], 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule